// File: doc/BRIEF.md
# Clock Frequency Change Sequencer

This block steps the system through a power-saving change of clock frequency. Software places a one-hot frequency code in a control input. When a legal code appears as a fresh 0-to-1 edge, the sequencer asks the system to freeze and waits for the freeze to be acknowledged. It then runs a fixed chain of timed phases: it asserts the clock-change strobes, asserts PLL bypass, releases bypass, releases the strobes, and after a settle period lifts the freeze. Each phase length comes from its own count input. All counts are in controller clocks, which run at half the system rate. Software is expected to clear the control value again some time after setting it, typically 16 system clocks later.

The accepted code is held aside while the sequence runs. It becomes the reported current frequency on the cycle the freeze lifts. A busy flag covers the whole sequence, and trigger activity while busy is discarded.

Top module: `cfs_sequencer`

## Requirements
- R1: After reset, freeze_no is 1, clk_chg_no is 3'b111, pll_bypass_o is 0, busy_o is 0 and freq_code_o is 8'h01.
- R2: When idle, if ctrl_i holds exactly one bit, that bit is one of 8'h01 (full), 8'h02 (half) or 8'h20 (1/32), and that bit was 0 on the previous edge, then freeze_no falls and busy_o rises on that same edge.
- R3: A ctrl_i value with more than one bit set, or with any bit of mask 8'hDC set, starts nothing.
- R4: A code held unchanged in ctrl_i does not start a second sequence. Changing ctrl_i directly from one legal code to another is a fresh edge and does start one.
- R5: The sequencer waits for freeze_ack_i without any time limit. All three clk_chg_no bits fall assert_chg_cnt_i+1 cycles after the edge on which freeze_ack_i is first sampled high in the freeze phase.
- R6: pll_bypass_o rises assert_byp_cnt_i+1 cycles after the strobes fall.
- R7: pll_bypass_o falls deassert_byp_cnt_i+1 cycles after it rose.
- R8: The strobes rise deassert_chg_cnt_i+1 cycles after pll_bypass_o falls.
- R9: freeze_no rises settle_cnt_i+1 cycles after the strobes rise. On that edge busy_o falls and freq_code_o takes the accepted code. freq_code_o changes at no other time.
- R10: Any change of ctrl_i while busy_o is 1 is discarded. It neither alters the running sequence nor starts a new one afterwards.
- R11: The three strobes always switch together. Bypass is high only while the strobes are asserted, and the strobes are asserted only while freeze_no is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock (half system rate) |
| rst_ni | input | 1 | Active-low synchronous reset |
| ctrl_i | input | 8 | Frequency request code from the control register |
| assert_chg_cnt_i | input | 8 | Cycles from acknowledge to strobe assertion |
| assert_byp_cnt_i | input | 16 | Cycles from strobe assertion to bypass assertion |
| deassert_byp_cnt_i | input | 8 | Cycles bypass stays asserted |
| deassert_chg_cnt_i | input | 8 | Cycles from bypass release to strobe release |
| settle_cnt_i | input | 32 | PLL settle cycles from strobe release to freeze release |
| freeze_ack_i | input | 1 | Freeze acknowledge from the system |
| freeze_no | output | 1 | Active-low freeze request |
| clk_chg_no | output | 3 | Active-low clock-change strobes |
| pll_bypass_o | output | 1 | PLL bypass request |
| busy_o | output | 1 | Sequence in progress |
| freq_code_o | output | 8 | Code of the frequency currently in effect |

## Verification
The ordering and legality properties assume only a synchronous reset. They hold however ctrl_i, freeze_ack_i and the counts move, because the sequencer samples each count only when it enters a phase and looks at the acknowledge only in the freeze phase. The stimulus holds every count steady for the length of a run and keeps the acknowledge high until the freeze lifts. It drives a request and lets it sit before clearing it, so each timed gap can be predicted from the count values alone. The test for R10 deliberately moves ctrl_i in the middle of a run, to show the change is discarded.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FREEZE,
        PH_CHG_WAIT,
        PH_BYP_WAIT,
        PH_BYP_HOLD,
        PH_CHG_HOLD,
        PH_SETTLE
    } phase_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/cfs_trigger.sv
module cfs_trigger #(
    parameter int unsigned        CODE_W     = 8,
    parameter logic [CODE_W-1:0]  VALID_MASK = 8'h23
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] ctrl_i,
    output logic              fire_o
);
    logic [CODE_W-1:0] prev_d, prev_q;
    logic              single, legal, fresh;

    always_comb begin
        prev_d = ctrl_i;
        single = (ctrl_i != '0) && ((ctrl_i & (ctrl_i - 1'b1)) == '0);
        legal  = (ctrl_i & ~VALID_MASK) == '0;
        fresh  = (ctrl_i & ~prev_q) != '0;
        fire_o = single && legal && fresh;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end
endmodule

// File: rtl/cfs_timer.sv
module cfs_timer #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)             cnt_d = load_val_i;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        done_o = (cnt_q == '0);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cfs_sequencer.sv
module cfs_sequencer
    import cfs_pkg::*;
#(
    parameter int unsigned        CODE_W     = 8,
    parameter int unsigned        STB_W      = 3,
    parameter int unsigned        ACH_W      = 8,
    parameter int unsigned        ABY_W      = 16,
    parameter int unsigned        DBY_W      = 8,
    parameter int unsigned        DCH_W      = 8,
    parameter int unsigned        SET_W      = 32,
    parameter logic [CODE_W-1:0]  VALID_MASK = 8'h23,
    parameter logic [CODE_W-1:0]  RESET_CODE = 8'h01
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CODE_W-1:0] ctrl_i,
    input  logic [ACH_W-1:0]  assert_chg_cnt_i,
    input  logic [ABY_W-1:0]  assert_byp_cnt_i,
    input  logic [DBY_W-1:0]  deassert_byp_cnt_i,
    input  logic [DCH_W-1:0]  deassert_chg_cnt_i,
    input  logic [SET_W-1:0]  settle_cnt_i,
    input  logic              freeze_ack_i,
    output logic              freeze_no,
    output logic [STB_W-1:0]  clk_chg_no,
    output logic              pll_bypass_o,
    output logic              busy_o,
    output logic [CODE_W-1:0] freq_code_o
);
    localparam int unsigned CNT_W =
        max2(max2(max2(ACH_W, ABY_W), max2(DBY_W, DCH_W)), SET_W);

    typedef struct packed {
        phase_e            phase;
        logic              freeze_n;
        logic [STB_W-1:0]  strobe_n;
        logic              bypass;
        logic [CODE_W-1:0] pend;
        logic [CODE_W-1:0] cur;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        phase:    PH_IDLE,
        freeze_n: 1'b1,
        strobe_n: '1,
        bypass:   1'b0,
        pend:     RESET_CODE,
        cur:      RESET_CODE
    };

    seq_t             s_d, s_q;
    logic             fire, tmr_done, tmr_load;
    logic [CNT_W-1:0] tmr_val;

    cfs_trigger #(
        .CODE_W     (CODE_W),
        .VALID_MASK (VALID_MASK)
    ) u_trigger (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .ctrl_i (ctrl_i),
        .fire_o (fire)
    );

    cfs_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (fire) begin
                    s_d.phase    = PH_FREEZE;
                    s_d.freeze_n = 1'b0;
                    s_d.pend     = ctrl_i;
                end
            end
            PH_FREEZE: begin
                if (freeze_ack_i) begin
                    s_d.phase = PH_CHG_WAIT;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(assert_chg_cnt_i);
                end
            end
            PH_CHG_WAIT: begin
                if (tmr_done) begin
                    s_d.phase    = PH_BYP_WAIT;
                    s_d.strobe_n = '0;
                    tmr_load     = 1'b1;
                    tmr_val      = CNT_W'(assert_byp_cnt_i);
                end
            end
            PH_BYP_WAIT: begin
                if (tmr_done) begin
                    s_d.phase  = PH_BYP_HOLD;
                    s_d.bypass = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(deassert_byp_cnt_i);
                end
            end
            PH_BYP_HOLD: begin
                if (tmr_done) begin
                    s_d.phase  = PH_CHG_HOLD;
                    s_d.bypass = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(deassert_chg_cnt_i);
                end
            end
            PH_CHG_HOLD: begin
                if (tmr_done) begin
                    s_d.phase    = PH_SETTLE;
                    s_d.strobe_n = '1;
                    tmr_load     = 1'b1;
                    tmr_val      = CNT_W'(settle_cnt_i);
                end
            end
            PH_SETTLE: begin
                if (tmr_done) begin
                    s_d.phase    = PH_IDLE;
                    s_d.freeze_n = 1'b1;
                    s_d.cur      = s_q.pend;
                end
            end
            default: s_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) s_q <= SEQ_RST;
        else         s_q <= s_d;
    end

    assign freeze_no    = s_q.freeze_n;
    assign clk_chg_no   = s_q.strobe_n;
    assign pll_bypass_o = s_q.bypass;
    assign busy_o       = (s_q.phase != PH_IDLE);
    assign freq_code_o  = s_q.cur;
endmodule

// File: rtl/cfs_sequencer_chk.sv
module cfs_sequencer_chk #(
    parameter int unsigned       CODE_W     = 8,
    parameter int unsigned       STB_W      = 3,
    parameter logic [CODE_W-1:0] VALID_MASK = 8'h23
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              freeze_no,
    input logic [STB_W-1:0]  clk_chg_no,
    input logic              pll_bypass_o,
    input logic              busy_o,
    input logic [CODE_W-1:0] freq_code_o
);
    AST_STROBES_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_chg_no == '0) || (clk_chg_no == '1)); // R11

    AST_BYPASS_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pll_bypass_o |-> (clk_chg_no == '0)); // R11

    AST_STROBE_NEEDS_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_chg_no != '1) |-> !freeze_no); // R11

    AST_BUSY_MATCHES_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o == !freeze_no); // R2

    AST_CODE_ONLY_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$fell(busy_o) |-> $stable(freq_code_o)); // R9

    AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot(freq_code_o) && ((freq_code_o & ~VALID_MASK) == '0)); // R9
endmodule

bind cfs_sequencer cfs_sequencer_chk #(
    .CODE_W     (CODE_W),
    .STB_W      (STB_W),
    .VALID_MASK (VALID_MASK)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .freeze_no    (freeze_no),
    .clk_chg_no   (clk_chg_no),
    .pll_bypass_o (pll_bypass_o),
    .busy_o       (busy_o),
    .freq_code_o  (freq_code_o)
);

// File: tb/cfs_sequencer_tb.sv
module cfs_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  ctrl;
    logic [7:0]  ach;
    logic [15:0] aby;
    logic [7:0]  dby;
    logic [7:0]  dch;
    logic [31:0] setl;
    logic        ack;
    logic        freeze_n;
    logic [2:0]  chg_n;
    logic        byp;
    logic        busy;
    logic [7:0]  code;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    typedef struct { int kind; int at; } ev_t;
    ev_t exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cfs_sequencer u_dut (
        .clk_i              (clk),
        .rst_ni             (rst_n),
        .ctrl_i             (ctrl),
        .assert_chg_cnt_i   (ach),
        .assert_byp_cnt_i   (aby),
        .deassert_byp_cnt_i (dby),
        .deassert_chg_cnt_i (dch),
        .settle_cnt_i       (setl),
        .freeze_ack_i       (ack),
        .freeze_no          (freeze_n),
        .clk_chg_no         (chg_n),
        .pll_bypass_o       (byp),
        .busy_o             (busy),
        .freq_code_o        (code)
    );

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string kind_req(int k);
        case (k)
            0: return "R2 freeze fall";
            1: return "R5 strobe fall";
            2: return "R6 bypass rise";
            3: return "R7 bypass fall";
            4: return "R8 strobe rise";
            default: return "R9 freeze rise";
        endcase
    endfunction

    task automatic note_event(int k);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R3/R4/R10 unexpected output event", k, -1);
        end else begin
            e = exp_q.pop_front();
            check(e.kind == k, kind_req(e.kind), k, e.kind);
            check(e.at == cyc, kind_req(e.kind), cyc, e.at);
        end
    endtask

    // Monitor: watches output edges and compares them against the scoreboard
    initial begin
        logic       pf;
        logic [2:0] pc;
        logic       pb;
        @(posedge rst_n);
        @(negedge clk);
        pf = freeze_n; pc = chg_n; pb = byp;
        forever begin
            @(negedge clk);
            if (chg_n != 3'b000 && chg_n != 3'b111)
                check(1'b0, "R11 strobes split", chg_n, 0);
            if (pf && !freeze_n) note_event(0);
            if (pc == 3'b111 && chg_n == 3'b000) note_event(1);
            if (!pb && byp) note_event(2);
            if (pb && !byp) note_event(3);
            if (pc == 3'b000 && chg_n == 3'b111) note_event(4);
            if (!pf && freeze_n) note_event(5);
            pf = freeze_n; pc = chg_n; pb = byp;
        end
    end

    task automatic push(int k, int at);
        ev_t e;
        e.kind = k;
        e.at   = at;
        exp_q.push_back(e);
    endtask

    // Driver: one full sequence; optionally disturbs ctrl while busy
    task automatic run_seq(logic [7:0] c, int a, int b, int db, int dc, int s,
                           int ack_dly, bit poke);
        int t;
        @(negedge clk);
        ach = 8'(a); aby = 16'(b); dby = 8'(db); dch = 8'(dc); setl = 32'(s);
        ctrl = c;
        push(0, cyc + 1);
        @(negedge clk);
        while (freeze_n) @(negedge clk);
        check(busy == 1'b1, "R2 busy during freeze", busy, 1);
        repeat (ack_dly) @(negedge clk);
        ack = 1'b1;
        t = cyc + 1 + a + 1; push(1, t);
        t = t + b + 1;       push(2, t);
        t = t + db + 1;      push(3, t);
        t = t + dc + 1;      push(4, t);
        t = t + s + 1;       push(5, t);
        if (poke) begin
            @(negedge clk); ctrl = 8'h00;
            @(negedge clk); ctrl = (c == 8'h20) ? 8'h01 : 8'h20;
        end
        @(negedge clk);
        while (!freeze_n) @(negedge clk);
        ack = 1'b0;
        check(busy == 1'b0, "R9 busy cleared", busy, 0);
        check(code == c, "R9 code updated", code, c);
    endtask

    task automatic expect_idle(int n, string req);
        bit ok = 1'b1;
        repeat (n) begin
            @(negedge clk);
            if (freeze_n !== 1'b1 || busy !== 1'b0) ok = 1'b0;
        end
        check(ok, req, busy, 0);
    endtask

    task automatic set_ctrl(logic [7:0] v);
        @(negedge clk);
        ctrl = v;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", cyc, 100000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ctrl = 8'h00; ack = 1'b0;
        ach = 8'd0; aby = 16'd0; dby = 8'd0; dch = 8'd0; setl = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(freeze_n == 1'b1, "R1 freeze", freeze_n, 1);
        check(chg_n == 3'b111, "R1 strobes", chg_n, 7);
        check(byp == 1'b0, "R1 bypass", byp, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(code == 8'h01, "R1 code", code, 1);

        // Main timeline with distinct counts, half frequency
        run_seq(8'h02, 3, 5, 2, 4, 6, 2, 1'b0);
        // R4: code still held, no second run
        expect_idle(12, "R4 held code ignored");
        set_ctrl(8'h00);

        // All counts zero, 1/32 frequency, immediate ack
        run_seq(8'h20, 0, 0, 0, 0, 0, 0, 1'b0);
        set_ctrl(8'h00);

        // R5 long ack wait, larger counts; R10 poke during busy
        run_seq(8'h01, 1, 300, 1, 1, 40, 20, 1'b1);
        expect_idle(12, "R10 busy-time trigger discarded");
        check(code == 8'h01, "R10 code unchanged", code, 1);

        // R3 illegal patterns
        set_ctrl(8'h00); set_ctrl(8'h03);
        expect_idle(8, "R3 two bits set");
        set_ctrl(8'h00); set_ctrl(8'h04);
        expect_idle(8, "R3 reserved 0x04");
        set_ctrl(8'h00); set_ctrl(8'h80);
        expect_idle(8, "R3 reserved 0x80");
        set_ctrl(8'h00); set_ctrl(8'h21);
        expect_idle(8, "R3 legal pair");
        // R4: from 0x21 to 0x01 gives no fresh edge
        set_ctrl(8'h01);
        expect_idle(8, "R4 no fresh edge");
        check(code == 8'h01, "R3 code unchanged", code, 1);

        // R4: direct change between legal codes starts a run
        set_ctrl(8'h00);
        run_seq(8'h01, 2, 1, 3, 0, 5, 1, 1'b0);
        run_seq(8'h02, 0, 7, 0, 2, 1, 3, 1'b0);
        set_ctrl(8'h00);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R9 all events seen", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule